// File: doc/BRIEF.md
# Studio-Range YCrCb to RGB Colour Converter

This block turns a stream of component video pixels into RGB. On each clock it can accept one pixel, given as a luma sample and two colour-difference samples, and it marks each pixel with a qualifying strobe. The block subtracts the studio-range black and mid-scale offsets and weights each sample with fixed-point constants scaled by 2048. It then sums the products for each primary, rounds to the nearest integer, saturates to the legal output range and registers the result. The output strobe follows the same pipeline, so each RGB triple appears with its own qualifier.

A single parameter sets the sample precision to 8 or 10 bits. The offsets and the saturation limit follow from that precision, while the five weights stay the same in both cases. The pipeline accepts a new pixel every clock, including back-to-back pixels, and has no stall input.

Top module: `ycc2rgb`

## Requirements
- R1: Red equals 1.164·(Y − Yoff) + 1.596·(Cr − Coff), where Yoff is 16 and Coff is 128 when DATA_W is 8.
- R2: Green equals 1.164·(Y − Yoff) − 0.813·(Cr − Coff) − 0.392·(Cb − Coff).
- R3: Blue equals 1.164·(Y − Yoff) + 2.017·(Cb − Coff).
- R4: With DATA_W set to 10, Yoff is 64, Coff is 512 and the outputs span 0 to 1023.
- R5: The weights are the integers 2384, 3269, 1665, 803 and 4131 over 2048. A term of 1024 is added before the 11-bit arithmetic shift, so every output is within 1 LSB of the exact real-valued result.
- R6: A channel whose result would be negative outputs 0.
- R7: A channel whose result would exceed 2^DATA_W − 1 outputs 2^DATA_W − 1.
- R8: out_valid is in_valid delayed by exactly 3 clock edges. The result for a pixel appears alongside that delayed strobe, and a new pixel may be presented on every clock.
- R9: While rst is high and on the first cycle after it, out_valid is 0 and all colour outputs are 0.
- R10: When Cr and Cb both equal Coff, the three outputs are equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input pixel qualifier |
| in_y | input | DATA_W | Luma sample |
| in_cr | input | DATA_W | Red-difference sample |
| in_cb | input | DATA_W | Blue-difference sample |
| out_valid | output | 1 | Output pixel qualifier |
| out_r | output | DATA_W | Red result |
| out_g | output | DATA_W | Green result |
| out_b | output | DATA_W | Blue result |

## Verification
Both precisions are driven in parallel. The bench uses fixed pixels at reference black, reference white and a saturated red, so an offset or a weight error shows up as a clear, directed difference. All-zero and all-maximum samples drive red and blue below zero and above full scale while green stays in range. This separates the lower and upper saturation paths from the plain arithmetic. Random pixels sent back to back and with idle gaps are compared against a real-valued model with a 1 LSB tolerance, and every pixel is checked for arrival exactly three clocks after issue. Neutral-chroma pixels must produce exactly equal channels.

// File: rtl/ycc2rgb_pkg.sv
package ycc2rgb_pkg;
    localparam int FRAC_BITS = 11;
    localparam int COEF_W    = 14;   // signed width holding the largest weight
    localparam int W_LUMA    = 2384; // 1.164
    localparam int W_CR_R    = 3269; // 1.596
    localparam int W_CR_G    = 1665; // 0.813
    localparam int W_CB_G    = 803;  // 0.392
    localparam int W_CB_B    = 4131; // 2.017
    localparam int HALF_LSB  = 1 << (FRAC_BITS - 1);
endpackage

// File: rtl/ycc_offset_stage.sv
module ycc_offset_stage #(
    parameter int DATA_W = 8,
    parameter int SW     = DATA_W + 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic [DATA_W-1:0]        in_y,
    input  logic [DATA_W-1:0]        in_cr,
    input  logic [DATA_W-1:0]        in_cb,
    output logic                     s1_valid,
    output logic signed [SW-1:0]     s1_y,
    output logic signed [SW-1:0]     s1_cr,
    output logic signed [SW-1:0]     s1_cb
);
    localparam logic signed [SW-1:0] LUMA_OFF   = SW'(16  << (DATA_W - 8));
    localparam logic signed [SW-1:0] CHROMA_OFF = SW'(128 << (DATA_W - 8));

    typedef struct packed {
        logic                 v;
        logic signed [SW-1:0] y;
        logic signed [SW-1:0] cr;
        logic signed [SW-1:0] cb;
    } ofs_t;

    ofs_t st_d, st_q;

    always_comb begin
        st_d.v  = in_valid;
        st_d.y  = $signed({2'b00, in_y})  - LUMA_OFF;
        st_d.cr = $signed({2'b00, in_cr}) - CHROMA_OFF;
        st_d.cb = $signed({2'b00, in_cb}) - CHROMA_OFF;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign s1_valid = st_q.v;
    assign s1_y     = st_q.y;
    assign s1_cr    = st_q.cr;
    assign s1_cb    = st_q.cb;
endmodule

// File: rtl/ycc_weight_stage.sv
module ycc_weight_stage
    import ycc2rgb_pkg::*;
#(
    parameter int SW = 10,
    parameter int PW = SW + COEF_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  s1_valid,
    input  logic signed [SW-1:0]  s1_y,
    input  logic signed [SW-1:0]  s1_cr,
    input  logic signed [SW-1:0]  s1_cb,
    output logic                  s2_valid,
    output logic signed [PW-1:0]  p_luma,
    output logic signed [PW-1:0]  p_cr_r,
    output logic signed [PW-1:0]  p_cr_g,
    output logic signed [PW-1:0]  p_cb_g,
    output logic signed [PW-1:0]  p_cb_b
);
    localparam logic signed [PW-1:0] K_LUMA = PW'(W_LUMA);
    localparam logic signed [PW-1:0] K_CR_R = PW'(W_CR_R);
    localparam logic signed [PW-1:0] K_CR_G = PW'(W_CR_G);
    localparam logic signed [PW-1:0] K_CB_G = PW'(W_CB_G);
    localparam logic signed [PW-1:0] K_CB_B = PW'(W_CB_B);

    typedef struct packed {
        logic                 v;
        logic signed [PW-1:0] luma;
        logic signed [PW-1:0] cr_r;
        logic signed [PW-1:0] cr_g;
        logic signed [PW-1:0] cb_g;
        logic signed [PW-1:0] cb_b;
    } prod_t;

    prod_t st_d, st_q;
    logic signed [PW-1:0] y_x, cr_x, cb_x;

    always_comb begin
        y_x       = PW'(s1_y);
        cr_x      = PW'(s1_cr);
        cb_x      = PW'(s1_cb);
        st_d.v    = s1_valid;
        st_d.luma = y_x  * K_LUMA;
        st_d.cr_r = cr_x * K_CR_R;
        st_d.cr_g = cr_x * K_CR_G;
        st_d.cb_g = cb_x * K_CB_G;
        st_d.cb_b = cb_x * K_CB_B;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign s2_valid = st_q.v;
    assign p_luma   = st_q.luma;
    assign p_cr_r   = st_q.cr_r;
    assign p_cr_g   = st_q.cr_g;
    assign p_cb_g   = st_q.cb_g;
    assign p_cb_b   = st_q.cb_b;
endmodule

// File: rtl/ycc_round_clamp.sv
module ycc_round_clamp
    import ycc2rgb_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int AW     = 26
) (
    input  logic signed [AW-1:0] acc,
    output logic [DATA_W-1:0]    val
);
    localparam logic signed [AW-1:0] RND   = AW'(HALF_LSB);
    localparam logic signed [AW-1:0] TOP_S = AW'((1 << DATA_W) - 1);

    logic signed [AW-1:0] biased, scaled;

    always_comb begin
        biased = acc + RND;
        scaled = biased >>> FRAC_BITS;
        if (scaled < 0)          val = '0;
        else if (scaled > TOP_S) val = '1;
        else                     val = DATA_W'(scaled);
    end
endmodule

// File: rtl/ycc2rgb.sv
module ycc2rgb
    import ycc2rgb_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_y,
    input  logic [DATA_W-1:0] in_cr,
    input  logic [DATA_W-1:0] in_cb,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_r,
    output logic [DATA_W-1:0] out_g,
    output logic [DATA_W-1:0] out_b
);
    localparam int SW     = DATA_W + 2;
    localparam int PW     = SW + COEF_W;
    localparam int AW     = PW + 2;
    localparam int N_CHAN = 3;

    logic                 s1_valid, s2_valid;
    logic signed [SW-1:0] s1_y, s1_cr, s1_cb;
    logic signed [PW-1:0] p_luma, p_cr_r, p_cr_g, p_cb_g, p_cb_b;
    logic signed [AW-1:0] acc   [N_CHAN];
    logic [DATA_W-1:0]    clamp [N_CHAN];

    ycc_offset_stage #(.DATA_W(DATA_W), .SW(SW)) u_ofs (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .in_y(in_y), .in_cr(in_cr), .in_cb(in_cb),
        .s1_valid(s1_valid), .s1_y(s1_y), .s1_cr(s1_cr), .s1_cb(s1_cb)
    );

    ycc_weight_stage #(.SW(SW), .PW(PW)) u_wgt (
        .clk(clk), .rst(rst), .s1_valid(s1_valid),
        .s1_y(s1_y), .s1_cr(s1_cr), .s1_cb(s1_cb),
        .s2_valid(s2_valid), .p_luma(p_luma), .p_cr_r(p_cr_r),
        .p_cr_g(p_cr_g), .p_cb_g(p_cb_g), .p_cb_b(p_cb_b)
    );

    always_comb begin
        acc[0] = AW'(p_luma) + AW'(p_cr_r);
        acc[1] = AW'(p_luma) - AW'(p_cr_g) - AW'(p_cb_g);
        acc[2] = AW'(p_luma) + AW'(p_cb_b);
    end

    for (genvar c = 0; c < N_CHAN; c++) begin : g_chan
        ycc_round_clamp #(.DATA_W(DATA_W), .AW(AW)) u_rc (
            .acc(acc[c]), .val(clamp[c])
        );
    end

    typedef struct packed {
        logic              v;
        logic [DATA_W-1:0] r;
        logic [DATA_W-1:0] g;
        logic [DATA_W-1:0] b;
    } pix_t;

    pix_t out_d, out_q;

    always_comb begin
        out_d.v = s2_valid;
        out_d.r = clamp[0];
        out_d.g = clamp[1];
        out_d.b = clamp[2];
    end

    always_ff @(posedge clk) begin
        if (rst) out_q <= '0;
        else     out_q <= out_d;
    end

    assign out_valid = out_q.v;
    assign out_r     = out_q.r;
    assign out_g     = out_q.g;
    assign out_b     = out_q.b;
endmodule

// File: rtl/ycc2rgb_chk.sv
module ycc2rgb_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [DATA_W-1:0] in_y,
    input logic [DATA_W-1:0] in_cr,
    input logic [DATA_W-1:0] in_cb,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_r,
    input logic [DATA_W-1:0] out_g,
    input logic [DATA_W-1:0] out_b
);
    localparam logic [DATA_W-1:0] Y_OFF = DATA_W'(16  << (DATA_W - 8));
    localparam logic [DATA_W-1:0] C_OFF = DATA_W'(128 << (DATA_W - 8));

    logic [1:0] age_q;
    always_ff @(posedge clk) begin
        if (rst)              age_q <= '0;
        else if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end

    assert_latency_R8: assert property (@(posedge clk) disable iff (rst)
        (age_q == 2'd3) |-> (out_valid == $past(in_valid, 3)));

    assert_reset_idle_R9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && out_r == '0 && out_g == '0 && out_b == '0));

    assert_floor_R6: assert property (@(posedge clk) disable iff (rst)
        (age_q == 2'd3 && $past(in_y, 3) <= Y_OFF && $past(in_cr, 3) <= C_OFF
         && $past(in_cb, 3) <= C_OFF) |-> (out_r == '0 && out_b == '0));

    assert_ceiling_R7: assert property (@(posedge clk) disable iff (rst)
        (age_q == 2'd3 && $past(in_y, 3) == '1 && $past(in_cr, 3) >= C_OFF
         && $past(in_cb, 3) >= C_OFF) |-> (out_r == '1 && out_b == '1));

    assert_neutral_R10: assert property (@(posedge clk) disable iff (rst)
        (age_q == 2'd3 && $past(in_cr, 3) == C_OFF && $past(in_cb, 3) == C_OFF)
        |-> (out_r == out_g && out_g == out_b));
endmodule

bind ycc2rgb ycc2rgb_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_y(in_y), .in_cr(in_cr),
    .in_cb(in_cb), .out_valid(out_valid), .out_r(out_r), .out_g(out_g),
    .out_b(out_b)
);

// File: tb/sim_ycc2rgb.sv
module sim_ycc2rgb;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD / 2) clk = ~clk;

    logic       a_vi, a_vo;
    logic [7:0] a_y, a_cr, a_cb, a_r, a_g, a_b;
    logic       b_vi, b_vo;
    logic [9:0] b_y, b_cr, b_cb, b_r, b_g, b_b;

    ycc2rgb #(.DATA_W(8)) u0 (
        .clk(clk), .rst(rst), .in_valid(a_vi), .in_y(a_y), .in_cr(a_cr),
        .in_cb(a_cb), .out_valid(a_vo), .out_r(a_r), .out_g(a_g), .out_b(a_b)
    );
    ycc2rgb #(.DATA_W(10)) u1 (
        .clk(clk), .rst(rst), .in_valid(b_vi), .in_y(b_y), .in_cr(b_cr),
        .in_cb(b_cb), .out_valid(b_vo), .out_r(b_r), .out_g(b_g), .out_b(b_b)
    );

    typedef struct { int y; int cr; int cb; int t; } item_t;
    item_t q8[$];
    item_t q10[$];

    int tests = 0;
    int fails = 0;
    int cyc   = 0;
    bit done  = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // Exact real-valued model (R1, R2, R3, R4)
    function automatic real ideal(int ch, int y, int cr, int cb, int w);
        real yo = real'(16 << (w - 8));
        real co = real'(128 << (w - 8));
        real yl = 1.164 * (real'(y) - yo);
        if (ch == 0) return yl + 1.596 * (real'(cr) - co);
        if (ch == 1) return yl - 0.813 * (real'(cr) - co) - 0.392 * (real'(cb) - co);
        return yl + 2.017 * (real'(cb) - co);
    endfunction

    // Tolerance of 1 LSB per R5, saturation per R6 and R7
    task automatic chk_chan(string tag, int act, int ch, item_t it, int w);
        real raw = ideal(ch, it.y, it.cr, it.cb, w);
        int  top = (1 << w) - 1;
        int  e;
        string t = tag;
        if (raw < 0.0)              begin e = 0;   t = "R6"; end
        else if (raw > real'(top))  begin e = top; t = "R7"; end
        else                        e = int'(raw);
        tests++;
        if (act - e > 1 || e - act > 1) begin
            fails++;
            $display("FAIL %s (R5 tol) w=%0d ch=%0d in=(%0d,%0d,%0d) got %0d exp %0d",
                     t, w, ch, it.y, it.cr, it.cb, act, e);
        end
    endtask

    task automatic chk_pixel(int w, item_t it, int r, int g, int b);
        int co = 128 << (w - 8);
        tests++;
        if (cyc != it.t + 3) begin
            fails++;
            $display("FAIL R8 w=%0d arrival cycle got %0d exp %0d", w, cyc, it.t + 3);
        end
        if (w == 8) begin
            chk_chan("R1", r, 0, it, w);
            chk_chan("R2", g, 1, it, w);
            chk_chan("R3", b, 2, it, w);
        end else begin
            chk_chan("R4", r, 0, it, w);
            chk_chan("R4", g, 1, it, w);
            chk_chan("R4", b, 2, it, w);
        end
        if (it.cr == co && it.cb == co) begin
            tests++;
            if (r != g || g != b) begin
                fails++;
                $display("FAIL R10 w=%0d got (%0d,%0d,%0d) exp equal", w, r, g, b);
            end
        end
    endtask

    // Monitor: pops expected items as results appear
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (a_vo) begin
                if (q8.size() == 0) begin
                    tests++; fails++;
                    $display("FAIL R8 w=8 unexpected out_valid got 1 exp 0");
                end else chk_pixel(8, q8.pop_front(), int'(a_r), int'(a_g), int'(a_b));
            end
            if (b_vo) begin
                if (q10.size() == 0) begin
                    tests++; fails++;
                    $display("FAIL R8 w=10 unexpected out_valid got 1 exp 0");
                end else chk_pixel(10, q10.pop_front(), int'(b_r), int'(b_g), int'(b_b));
            end
        end
    end

    // Driver: presents one pixel to each instance and queues the expectation
    task automatic send(int y8, int cr8, int cb8, int y10, int cr10, int cb10);
        @(negedge clk);
        a_vi = 1'b1; a_y = 8'(y8); a_cr = 8'(cr8); a_cb = 8'(cb8);
        b_vi = 1'b1; b_y = 10'(y10); b_cr = 10'(cr10); b_cb = 10'(cb10);
        q8.push_back('{y8, cr8, cb8, cyc});
        q10.push_back('{y10, cr10, cb10, cyc});
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            a_vi = 1'b0; b_vi = 1'b0;
        end
    endtask

    task automatic finish_run();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog expired got timeout exp completion");
        finish_run();
    end

    initial begin
        a_vi = 0; a_y = 0; a_cr = 0; a_cb = 0;
        b_vi = 0; b_y = 0; b_cr = 0; b_cb = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        tests++;
        if (a_vo || b_vo || a_r != 0 || a_g != 0 || a_b != 0 || b_r != 0) begin
            fails++;
            $display("FAIL R9 during reset got valid=%0d/%0d exp 0", a_vo, b_vo);
        end
        rst = 1'b0;
        @(negedge clk);
        tests++;
        if (a_vo || b_vo || a_r != 0 || b_g != 0) begin
            fails++;
            $display("FAIL R9 after reset got valid=%0d/%0d exp 0", a_vo, b_vo);
        end
        // Reference black, white and mid grey (R1..R4, R10)
        send(16, 128, 128, 64, 512, 512);
        send(235, 128, 128, 940, 512, 512);
        send(126, 128, 128, 503, 512, 512);
        // Saturated red, green-ish and blue-ish pixels
        send(81, 240, 90, 324, 960, 360);
        send(145, 34, 54, 580, 136, 216);
        send(41, 110, 240, 164, 440, 960);
        idle(2);
        // Lower saturation (R6) and upper saturation (R7)
        send(0, 0, 0, 0, 0, 0);
        send(255, 255, 255, 1023, 1023, 1023);
        send(16, 0, 255, 64, 0, 1023);
        send(255, 255, 0, 1023, 1023, 0);
        idle(3);
        // Random pixels with gaps and back-to-back runs
        for (int i = 0; i < 400; i++) begin
            send(int'($urandom_range(255)), int'($urandom_range(255)), int'($urandom_range(255)),
                 int'($urandom_range(1023)), int'($urandom_range(1023)), int'($urandom_range(1023)));
            if ($urandom_range(3) == 0) idle(int'($urandom_range(2)) + 1);
        end
        idle(8);
        tests++;
        if (q8.size() != 0 || q10.size() != 0) begin
            fails++;
            $display("FAIL R8 missing results got %0d/%0d pending exp 0", q8.size(), q10.size());
        end
        finish_run();
    end
endmodule